// File: doc/BRIEF.md
# Misaligned Access Splitting Bus Bridge

The bridge sits between a 32-bit little-endian internal master bus and an external memory port that only understands naturally aligned transfers. Each internal request arrives with its address, size code, misalignment flag, byte strobes, chip-select hit and burst flag. A request the bridge can serve is broken into one or more aligned external beats sized to the configured port width (8, 16 or 32 bits). Read bytes from those beats are collected into a holding word that is returned to the master once the final beat completes.

Requests the bridge cannot serve are answered with an error response and no external cycle at all. Chip-select decoding, wait states and arbitration are done elsewhere. The port width is a static per-region setting applied by the surrounding logic. The external data bus is big-endian, so the lane position of each byte is mirrored relative to the internal bus.

Top module: `msplit_bridge`

## Requirements
- R1: After reset, `req_ready` is 1 and `ext_valid` and `resp_valid` are 0.
- R2: A request is rejected when its size code is 2'b11, when `req_unaligned` is set together with `req_burst` or with `req_cs_hit` low, or when `req_burst` is set and `req_addr[1:0]` is not 0. A rejected request gives `resp_valid` and `resp_err` high for one cycle, starting one cycle after acceptance, and `ext_valid` stays low throughout.
- R3: The size code 2'b00, 2'b01 and 2'b10 names a container of 1, 2 or 4 bytes, whose base is the request address rounded down to the container size. A 2'b01 request at byte offset 3 is treated as a 1-byte container.
- R4: The number of external beats is the container size divided by the port size, and at least 1. The port size code `port_w` is 2'b00 for 8 bits, 2'b01 for 16 bits and 2'b10 for 32 bits.
- R5: The first beat address is the container base rounded down to the port size. Each following beat is the port size in bytes higher, so beats run in ascending order. `ext_addr[31:2]` equals `req_addr[31:2]`.
- R6: Byte j of a beat (j from 0, counting from the beat address) sits on `ext_wdata`/`ext_rdata` bits [31-8j -: 8]. `ext_lane_en` bit 3-j equals `req_strb` bit ((beat offset + j) mod 4). Lanes outside the port width are disabled.
- R7: `ext_write` follows `req_write`. On a disabled lane, `ext_wdata` carries zero. On an enabled lane, it carries the internal byte from lane (beat offset + j) mod 4 of `req_wdata`.
- R8: For reads, the holding word is cleared on accept. Each acknowledged beat copies external lane 3-j into internal lane (beat offset + j) mod 4. `resp_rdata` shows the holding word while `resp_valid` is high, and is zero for writes.
- R9: `req_ready` is low from the cycle after acceptance until the response cycle has ended. `resp_valid` is high for exactly one cycle, the cycle after the last beat's acknowledge.
- R10: `ext_valid` and `ext_addr` hold steady while `ext_ack` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| port_w | input | 2 | Static external port size code |
| req_valid | input | 1 | Internal request present |
| req_ready | output | 1 | Bridge idle, request accepted when valid |
| req_addr | input | 32 | Internal byte address |
| req_size | input | 2 | Container size code |
| req_unaligned | input | 1 | Request flagged as misaligned |
| req_strb | input | 4 | Internal byte strobes, bit k for lane k |
| req_cs_hit | input | 1 | Address falls in a chip-select region |
| req_burst | input | 1 | Request belongs to a burst |
| req_write | input | 1 | 1 for write, 0 for read |
| req_wdata | input | 32 | Internal write data, little-endian lanes |
| resp_valid | output | 1 | Response for the accepted request |
| resp_err | output | 1 | Response is a misaligned-access error |
| resp_rdata | output | 32 | Assembled read data |
| ext_valid | output | 1 | External beat requested |
| ext_ack | input | 1 | External beat completes this cycle |
| ext_addr | output | 32 | Aligned external beat address |
| ext_write | output | 1 | External beat direction |
| ext_lane_en | output | 4 | External byte lanes valid, big-endian order |
| ext_wdata | output | 32 | External write data |
| ext_rdata | input | 32 | External read data |

## Verification
The assertions assume that `port_w` does not change while a request is in flight and never takes the code 2'b11. They also assume the external side acknowledges only while `ext_valid` is high. The stimulus sets the port size code once per request, draws it from the three legal values, and drives `ext_ack` only in cycles where the bench has seen `ext_valid`. The acknowledge is randomly delayed so that the hold-steady rule is exercised. Random sizes, offsets, flags and strobes are mixed with fixed cases for every rejection rule and for the split layouts of the misaligned halfword and word.

// File: rtl/msplit_pkg.sv
package msplit_pkg;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int LANES  = DATA_W / 8;
    localparam int OFF_W  = $clog2(LANES);
    localparam int WORD_W = ADDR_W - OFF_W;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_BEAT,
        ST_RESP,
        ST_ERR
    } st_e;

    typedef struct packed {
        st_e                st;
        logic [WORD_W-1:0]  word;
        logic [OFF_W-1:0]   off;
        logic [OFF_W-1:0]   left;
        logic [1:0]         pwl;
        logic               wr;
        logic [LANES-1:0]   strb;
        logic [DATA_W-1:0]  wdata;
        logic [DATA_W-1:0]  hold;
    } ctx_t;
endpackage

// File: rtl/msplit_classify.sv
module msplit_classify
    import msplit_pkg::*;
(
    input  logic [OFF_W-1:0] off,
    input  logic [1:0]       size,
    input  logic             unaligned,
    input  logic             cs_hit,
    input  logic             burst,
    input  logic [1:0]       pwl,
    output logic             err,
    output logic [OFF_W-1:0] first_off,
    output logic [OFF_W-1:0] beats_m1
);
    logic [1:0]       eff;
    logic [OFF_W-1:0] cmask;
    logic [OFF_W-1:0] pmask;

    always_comb begin
        // a halfword at the last byte of a word only needs its first byte here
        eff       = (size == 2'b01 && off == '1) ? 2'b00 : size;
        cmask     = OFF_W'((1 << eff) - 1);
        pmask     = OFF_W'((1 << pwl) - 1);
        first_off = off & ~cmask & ~pmask;
        beats_m1  = (eff > pwl) ? OFF_W'((1 << (eff - pwl)) - 1) : '0;
        err       = (size == 2'b11)
                  || (unaligned && (!cs_hit || burst))
                  || (burst && off != '0);
    end
endmodule

// File: rtl/msplit_lanes.sv
module msplit_lanes
    import msplit_pkg::*;
(
    input  logic [OFF_W-1:0]  off,
    input  logic [1:0]        pwl,
    input  logic [LANES-1:0]  strb,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] rdata,
    input  logic [DATA_W-1:0] hold_in,
    output logic [LANES-1:0]  lane_en,
    output logic [DATA_W-1:0] ext_wdata,
    output logic [DATA_W-1:0] hold_out
);
    logic [OFF_W-1:0] src;

    always_comb begin
        lane_en   = '0;
        ext_wdata = '0;
        hold_out  = hold_in;
        src       = '0;
        for (int j = 0; j < LANES; j++) begin
            if (j < (1 << pwl)) begin
                src = off + OFF_W'(j);
                lane_en[LANES-1-j] = strb[src];
                if (strb[src]) begin
                    ext_wdata[(LANES-1-j)*8 +: 8] = wdata[int'(src)*8 +: 8];
                end
                hold_out[int'(src)*8 +: 8] = rdata[(LANES-1-j)*8 +: 8];
            end
        end
    end
endmodule

// File: rtl/msplit_bridge.sv
module msplit_bridge
    import msplit_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        port_w,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_unaligned,
    input  logic [LANES-1:0]  req_strb,
    input  logic              req_cs_hit,
    input  logic              req_burst,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              resp_valid,
    output logic              resp_err,
    output logic [DATA_W-1:0] resp_rdata,
    output logic              ext_valid,
    input  logic              ext_ack,
    output logic [ADDR_W-1:0] ext_addr,
    output logic              ext_write,
    output logic [LANES-1:0]  ext_lane_en,
    output logic [DATA_W-1:0] ext_wdata,
    input  logic [DATA_W-1:0] ext_rdata
);
    ctx_t             ctx_d, ctx_q;
    logic [1:0]       pwl_in;
    logic             rej;
    logic [OFF_W-1:0] first_off;
    logic [OFF_W-1:0] beats_m1;
    logic [DATA_W-1:0] merged;

    assign pwl_in = (port_w == 2'b11) ? 2'b10 : port_w;

    msplit_classify u_cls (
        .off       (req_addr[OFF_W-1:0]),
        .size      (req_size),
        .unaligned (req_unaligned),
        .cs_hit    (req_cs_hit),
        .burst     (req_burst),
        .pwl       (pwl_in),
        .err       (rej),
        .first_off (first_off),
        .beats_m1  (beats_m1)
    );

    msplit_lanes u_lanes (
        .off       (ctx_q.off),
        .pwl       (ctx_q.pwl),
        .strb      (ctx_q.strb),
        .wdata     (ctx_q.wdata),
        .rdata     (ext_rdata),
        .hold_in   (ctx_q.hold),
        .lane_en   (ext_lane_en),
        .ext_wdata (ext_wdata),
        .hold_out  (merged)
    );

    always_comb begin
        ctx_d = ctx_q;
        unique case (ctx_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    ctx_d.word  = req_addr[ADDR_W-1:OFF_W];
                    ctx_d.off   = first_off;
                    ctx_d.left  = beats_m1;
                    ctx_d.pwl   = pwl_in;
                    ctx_d.wr    = req_write;
                    ctx_d.strb  = req_strb;
                    ctx_d.wdata = req_wdata;
                    ctx_d.hold  = '0;
                    ctx_d.st    = rej ? ST_ERR : ST_BEAT;
                end
            end
            ST_BEAT: begin
                if (ext_ack) begin
                    if (!ctx_q.wr) begin
                        ctx_d.hold = merged;
                    end
                    if (ctx_q.left == '0) begin
                        ctx_d.st = ST_RESP;
                    end else begin
                        ctx_d.left = ctx_q.left - 1'b1;
                        ctx_d.off  = ctx_q.off + OFF_W'(1 << ctx_q.pwl);
                    end
                end
            end
            ST_RESP: ctx_d.st = ST_IDLE;
            ST_ERR:  ctx_d.st = ST_IDLE;
            default: ctx_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctx_q <= '{st: ST_IDLE, default: '0};
        end else begin
            ctx_q <= ctx_d;
        end
    end

    assign req_ready  = (ctx_q.st == ST_IDLE);
    assign ext_valid  = (ctx_q.st == ST_BEAT);
    assign ext_addr   = {ctx_q.word, ctx_q.off};
    assign ext_write  = ctx_q.wr;
    assign resp_valid = (ctx_q.st == ST_RESP) || (ctx_q.st == ST_ERR);
    assign resp_err   = (ctx_q.st == ST_ERR);
    assign resp_rdata = ctx_q.hold;
endmodule

// File: rtl/msplit_bridge_chk.sv
module msplit_bridge_chk
    import msplit_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        port_w,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_unaligned,
    input logic              req_cs_hit,
    input logic              req_burst,
    input logic              resp_valid,
    input logic              resp_err,
    input logic              ext_valid,
    input logic              ext_ack,
    input logic [ADDR_W-1:0] ext_addr,
    input logic              ext_write,
    input logic [LANES-1:0]  ext_lane_en,
    input logic [DATA_W-1:0] ext_wdata
);
    logic [DATA_W-1:0] lane_mask;

    always_comb begin
        lane_mask = '0;
        for (int k = 0; k < LANES; k++) begin
            lane_mask[k*8 +: 8] = {8{ext_lane_en[k]}};
        end
    end

    // R9
    busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_valid |-> !req_ready);

    // R9
    one_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    // R9
    resp_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> !req_ready && !ext_valid);

    // R10
    hold_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_valid && !ext_ack |=> ext_valid && $stable(ext_addr));

    // R2
    reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && req_unaligned && (req_burst || !req_cs_hit)
        |=> resp_valid && resp_err && !ext_valid);

    // R5
    half_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_valid && port_w == 2'b01 |-> !ext_addr[0]);

    // R5
    word_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_valid && port_w[1] |-> ext_addr[1:0] == 2'b00);

    // R6
    byte_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_valid && port_w == 2'b00 |-> ext_lane_en[LANES-2:0] == '0);

    // R7
    idle_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_valid && ext_write |-> (ext_wdata & ~lane_mask) == '0);
endmodule

bind msplit_bridge msplit_bridge_chk u_chk (.*);

// File: tb/msplit_bridge_test.sv
`timescale 1ns/1ps
module msplit_bridge_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  port_w = 2'b10;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic        req_unaligned = 1'b0;
    logic [3:0]  req_strb = '0;
    logic        req_cs_hit = 1'b0;
    logic        req_burst = 1'b0;
    logic        req_write = 1'b0;
    logic [31:0] req_wdata = '0;
    logic        resp_valid, resp_err;
    logic [31:0] resp_rdata;
    logic        ext_valid;
    logic        ext_ack = 1'b0;
    logic [31:0] ext_addr;
    logic        ext_write;
    logic [3:0]  ext_lane_en;
    logic [31:0] ext_wdata;
    logic [31:0] ext_rdata = '0;

    int n_vec = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    msplit_bridge uut (.*);

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int eff_of(int size, int off);
        return (size == 1 && off == 3) ? 0 : size;
    endfunction

    function automatic bit rej_of(int size, int off, bit un, bit cs, bit bu);
        return (size == 3) || (un && (!cs || bu)) || (bu && off != 0);
    endfunction

    function automatic int beats_of(int eff, int pwl);
        return (eff > pwl) ? (1 << (eff - pwl)) : 1;
    endfunction

    function automatic int first_of(int off, int eff, int pwl);
        return off & ~((1 << eff) - 1) & ~((1 << pwl) - 1) & 3;
    endfunction

    task automatic txn(input logic [31:0] a, input int size, input bit un, input bit cs,
                       input bit bu, input bit wr, input logic [3:0] st, input logic [31:0] wd,
                       input int pw);
        int off = int'(a[1:0]);
        int pwl = pw;
        int eff = eff_of(size, off);
        bit rej = rej_of(size, off, un, cs, bu);
        int nb = rej ? 0 : beats_of(eff, pwl);
        int b0 = first_of(off, eff, pwl);
        int pb = 1 << pwl;
        int k = 0;
        int guard = 0;
        logic [31:0] hold = '0;
        port_w = 2'(pw);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_size = 2'(size); req_unaligned = un;
        req_cs_hit = cs; req_burst = bu; req_write = wr; req_strb = st; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        while (!resp_valid && guard < 40) begin
            guard++;
            chk(!req_ready, "R9 ready low while busy", 32'(req_ready), 0);
            ext_ack = 1'b0;
            if (ext_valid) begin
                if (k >= nb) begin
                    chk(0, "R2/R4 unexpected external beat", ext_addr, 32'(nb));
                    ext_ack = 1'b1;
                end else if ($urandom_range(3) != 0) begin
                    int bo = b0 + k * pb;
                    logic [3:0] le = '0;
                    logic [31:0] ew = '0;
                    logic [31:0] rd = $urandom;
                    for (int j = 0; j < pb; j++) begin
                        int s = (bo + j) & 3;
                        le[3-j] = st[s];
                        if (st[s]) ew[(3-j)*8 +: 8] = wd[s*8 +: 8];
                        hold[s*8 +: 8] = rd[(3-j)*8 +: 8];
                    end
                    chk(ext_addr == {a[31:2], 2'(bo)}, "R5 beat address", ext_addr, {a[31:2], 2'(bo)});
                    chk(ext_lane_en == le, "R6 lane enables", 32'(ext_lane_en), 32'(le));
                    chk(ext_write == wr, "R7 direction", 32'(ext_write), 32'(wr));
                    if (wr) chk(ext_wdata == ew, "R7 write lanes", ext_wdata, ew);
                    ext_rdata = rd;
                    ext_ack = 1'b1;
                    k++;
                end
            end
            @(negedge clk);
        end
        ext_ack = 1'b0;
        chk(resp_valid, "R9 response arrives", 32'(resp_valid), 1);
        chk(k == nb, "R4 beat count", 32'(k), 32'(nb));
        chk(resp_err == rej, "R2 error flag", 32'(resp_err), 32'(rej));
        if (!rej) begin
            logic [31:0] exp = wr ? 32'h0 : hold;
            chk(resp_rdata == exp, "R8 read data", resp_rdata, exp);
        end
        @(negedge clk);
        chk(req_ready && !resp_valid, "R9 idle after response", {req_ready, resp_valid}, 32'h2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(req_ready && !ext_valid && !resp_valid, "R1 reset outputs",
            {req_ready, ext_valid, resp_valid}, 32'h4);
        rst_n = 1'b1;
        @(negedge clk);
        // R3 halfword at offset 3 behaves as a byte: one beat on 16-bit port
        txn(32'h0000_1003, 1, 1, 1, 0, 0, 4'b1000, 32'h0, 1);
        // R3 second half in next word, 8-bit port
        txn(32'h0000_1004, 0, 0, 1, 0, 1, 4'b0001, 32'hA1B2C3D4, 0);
        // R4 word at offset 1 on 8-bit port: four beats
        txn(32'h0000_2001, 2, 1, 1, 0, 0, 4'b1110, 32'h0, 0);
        // R6 R7 halfword at offset 1 in word container, 16-bit write
        txn(32'h0000_3001, 2, 1, 1, 0, 1, 4'b0110, 32'h11223344, 1);
        // R2 misaligned burst, misaligned outside chip select, offset burst, size 11
        txn(32'h0000_4002, 2, 1, 1, 1, 0, 4'b1100, 32'h0, 2);
        txn(32'h0000_4001, 1, 1, 0, 0, 1, 4'b0110, 32'h55AA55AA, 1);
        txn(32'h0000_4002, 1, 0, 1, 1, 0, 4'b1100, 32'h0, 1);
        txn(32'h0000_4000, 3, 0, 1, 0, 0, 4'b1111, 32'h0, 2);
        // R8 aligned burst word on 32-bit port
        txn(32'h0000_5000, 2, 0, 1, 1, 0, 4'b1111, 32'h0, 2);
        for (int i = 0; i < 300; i++) begin
            int size = ($urandom_range(15) == 0) ? 3 : $urandom_range(2);
            logic [31:0] a = $urandom;
            int sz = (size == 3) ? 0 : size;
            bit un = (a[1:0] & 2'((1 << sz) - 1)) != 0;
            txn(a, size, un, $urandom_range(5) != 0, $urandom_range(7) == 0,
                $urandom_range(1) == 1, 4'($urandom), $urandom, $urandom_range(2));
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule